// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a flash controller. It watches a stream of single-cycle bus writes, each with an address and a data word, and picks out multi-cycle command sequences. In normal mode every command starts with a two-write unlock prefix. In bypass mode the prefix is dropped, so long runs of programming take fewer bus writes. When a sequence completes, the block issues a one-cycle start pulse for a single-word program, a start pulse for a two-word program, a configuration write, or a bypass-mode entry or exit.

The block also holds the bypass-mode flag and a 16-bit configuration register. It takes a per-block protection mask from outside and refuses to start a program on a protected block. Erase handling, program timing, status reporting and the storage array belong to other blocks.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset `bypass_o` is 0, `cfg_o` is 0 and every pulse output is 0.
- R2: The write sequence AAh@555h, 55h@2AAh, A0h@555h, then (A, D) gives `prog_start_o`=1 for exactly one cycle, with `prog_addr_o`=A and `prog_data_o`=D. The pulse is registered on the clock edge that accepts the last write. Only `data_i[7:0]` is compared against command codes. Only `addr_i[10:0]` is compared against the unlock addresses.
- R3: A write that does not match the next expected step of a sequence returns the decoder to idle, and the sequence that was in progress produces no pulse.
- R4: Unlock, then 60h@555h, then a write whose low data byte is 03h, loads `cfg_o` with `addr_i[15:0]` and pulses `cfg_wr_o`. Any other data byte in that last write leaves `cfg_o` unchanged.
- R5: Unlock, then 20h@555h, sets `bypass_o` and pulses `byp_enter_o`.
- R6: In bypass mode, A0h written to any address followed by a write (A, D) pulses `prog_start_o` with A and D. The unlock prefix is not needed.
- R7: In bypass mode, 90h and then 00h clears `bypass_o` and pulses `byp_exit_o`. 90h followed by any other byte leaves bypass set. After the exit, A0h with no unlock prefix starts nothing.
- R8: Unlock, 40h@555h, (A, D0), then (A with bit 0 inverted, D1) pulses `dw_start_o` with `dw_addr_o`=A, `dw_data0_o`=D0 and `dw_data1_o`=D1.
- R9: In bypass mode, 40h at any address followed by the two data writes of R8 gives the same two-word program pulse.
- R10: In a two-word program, if the second address differs from the first in any bit other than bit 0, or equals the first, no pulse is produced.
- R11: The block index is `addr_i[20:17]`. If the bit of `prot_mask_i` for that block is 1 in the cycle of the target-address write, a program or two-word program is rejected and no start pulse is produced.
- R12: In bypass mode, writes that are not A0h, 40h or 90h are ignored. This includes the unlock bytes and 20h, which leave `bypass_o` set and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | One bus write this cycle |
| addr_i | input | 21 | Write address |
| data_i | input | 16 | Write data |
| prot_mask_i | input | 16 | Per-block protection, one bit per block |
| prog_start_o | output | 1 | Single-word program start pulse |
| prog_addr_o | output | 21 | Program target address |
| prog_data_o | output | 16 | Program data |
| dw_start_o | output | 1 | Two-word program start pulse |
| dw_addr_o | output | 21 | Address of the first word |
| dw_data0_o | output | 16 | Data for the first address |
| dw_data1_o | output | 16 | Data for the paired address |
| cfg_wr_o | output | 1 | Configuration register written |
| cfg_o | output | 16 | Configuration register |
| bypass_o | output | 1 | Bypass mode active |
| byp_enter_o | output | 1 | Bypass entered pulse |
| byp_exit_o | output | 1 | Bypass exited pulse |

## Verification
Two functions can act in the same cycle: the protection lookup and the final write of a program. Both are triggered by that one write. The bench provokes this by changing `prot_mask_i` at the same clock edge as the bypass program's data write, and it gives that data the value A0h, which is also a command code. A correct design starts the program, because the mask belongs to that cycle, and treats A0h as data rather than as a new command.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_CFG, ST_PGM, ST_DW_A, ST_DW_B, ST_EXIT
  } fcd_state_e;

  localparam int          UNL_AW        = 11;
  localparam logic [10:0] UNL_ADDR_A    = 11'h555;
  localparam logic [10:0] UNL_ADDR_B    = 11'h2AA;

  localparam logic [7:0]  CMD_UNL_A     = 8'hAA;
  localparam logic [7:0]  CMD_UNL_B     = 8'h55;
  localparam logic [7:0]  CMD_PGM       = 8'hA0;
  localparam logic [7:0]  CMD_DWORD     = 8'h40;
  localparam logic [7:0]  CMD_CFG       = 8'h60;
  localparam logic [7:0]  CMD_CFG_CONF  = 8'h03;
  localparam logic [7:0]  CMD_BYP_ENTER = 8'h20;
  localparam logic [7:0]  CMD_BYP_EXIT  = 8'h90;
  localparam logic [7:0]  CMD_EXIT_CONF = 8'h00;
endpackage

// File: rtl/fcd_prot_check.sv
module fcd_prot_check #(
  parameter int BLK_W = 4
) (
  input  logic [BLK_W-1:0]       blk_i,
  input  logic [(1<<BLK_W)-1:0]  mask_i,
  output logic                   prot_o
);
  localparam int NUM_BLK = 1 << BLK_W;

  logic [NUM_BLK-1:0] hit;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    assign hit[b] = (blk_i == BLK_W'(b)) & mask_i[b];
  end

  assign prot_o = |hit;

  always_comb begin
    a_r11_hit_onehot: assert ($onehot0(hit));
  end
endmodule

// File: rtl/fcd_cfg_reg.sv
module fcd_cfg_reg #(
  parameter int CFG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [CFG_W-1:0] val_i,
  output logic [CFG_W-1:0] cfg_o
);
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (ld_i) cfg_q <= val_i;
  end

  assign cfg_o = cfg_q;

  a_r4_cfg_only_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q != $past(cfg_q)) |-> $past(ld_i));
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int CFG_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              prot_i,
  output logic              prog_start_o,
  output logic [ADDR_W-1:0] prog_addr_o,
  output logic [DATA_W-1:0] prog_data_o,
  output logic              dw_start_o,
  output logic [ADDR_W-1:0] dw_addr_o,
  output logic [DATA_W-1:0] dw_data0_o,
  output logic [DATA_W-1:0] dw_data1_o,
  output logic              cfg_ld_o,
  output logic [CFG_W-1:0]  cfg_val_o,
  output logic              cfg_wr_o,
  output logic              bypass_o,
  output logic              byp_enter_o,
  output logic              byp_exit_o
);
  fcd_state_e st_q, st_d;
  logic byp_q, byp_d;
  logic prog_d, dw_d, cfgw_d, ent_d, ext_d, dw_first_ld;
  logic prog_q, dw_q, cfgw_q, ent_q, ext_q;
  logic [ADDR_W-1:0] prog_addr_q, dw_addr_q;
  logic [DATA_W-1:0] prog_data_q, dw_d0_q, dw_d1_q;

  logic [7:0]        cmd;
  logic [UNL_AW-1:0] lo;
  logic              pair_ok;

  assign cmd     = data_i[7:0];
  assign lo      = addr_i[UNL_AW-1:0];
  assign pair_ok = (addr_i == (dw_addr_q ^ ADDR_W'(1)));

  always_comb begin
    st_d        = st_q;
    byp_d       = byp_q;
    prog_d      = 1'b0;
    dw_d        = 1'b0;
    cfgw_d      = 1'b0;
    ent_d       = 1'b0;
    ext_d       = 1'b0;
    dw_first_ld = 1'b0;
    cfg_ld_o    = 1'b0;
    cfg_val_o   = addr_i[CFG_W-1:0];
    if (wr_i) begin
      unique case (st_q)
        ST_IDLE: begin
          if (byp_q) begin
            unique case (cmd)
              CMD_PGM:      st_d = ST_PGM;
              CMD_DWORD:    st_d = ST_DW_A;
              CMD_BYP_EXIT: st_d = ST_EXIT;
              default:      st_d = ST_IDLE;
            endcase
          end else if (cmd == CMD_UNL_A && lo == UNL_ADDR_A) begin
            st_d = ST_UNL1;
          end
        end
        ST_UNL1: st_d = (cmd == CMD_UNL_B && lo == UNL_ADDR_B) ? ST_UNL2 : ST_IDLE;
        ST_UNL2: begin
          st_d = ST_IDLE;
          if (lo == UNL_ADDR_A) begin
            unique case (cmd)
              CMD_PGM:   st_d = ST_PGM;
              CMD_DWORD: st_d = ST_DW_A;
              CMD_CFG:   st_d = ST_CFG;
              CMD_BYP_ENTER: begin
                byp_d = 1'b1;
                ent_d = 1'b1;
              end
              default: st_d = ST_IDLE;
            endcase
          end
        end
        ST_CFG: begin
          st_d = ST_IDLE;
          if (cmd == CMD_CFG_CONF) begin
            cfgw_d   = 1'b1;
            cfg_ld_o = 1'b1;
          end
        end
        ST_PGM: begin
          st_d   = ST_IDLE;
          prog_d = !prot_i;
        end
        ST_DW_A: begin
          if (!prot_i) begin
            st_d        = ST_DW_B;
            dw_first_ld = 1'b1;
          end else begin
            st_d = ST_IDLE;
          end
        end
        ST_DW_B: begin
          st_d = ST_IDLE;
          dw_d = pair_ok;
        end
        ST_EXIT: begin
          st_d = ST_IDLE;
          if (cmd == CMD_EXIT_CONF) begin
            byp_d = 1'b0;
            ext_d = 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      byp_q  <= 1'b0;
      prog_q <= 1'b0;
      dw_q   <= 1'b0;
      cfgw_q <= 1'b0;
      ent_q  <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      byp_q  <= byp_d;
      prog_q <= prog_d;
      dw_q   <= dw_d;
      cfgw_q <= cfgw_d;
      ent_q  <= ent_d;
      ext_q  <= ext_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_addr_q <= '0;
      prog_data_q <= '0;
      dw_addr_q   <= '0;
      dw_d0_q     <= '0;
      dw_d1_q     <= '0;
    end else begin
      if (prog_d) begin
        prog_addr_q <= addr_i;
        prog_data_q <= data_i;
      end
      if (dw_first_ld) begin
        dw_addr_q <= addr_i;
        dw_d0_q   <= data_i;
      end
      if (dw_d) dw_d1_q <= data_i;
    end
  end

  assign prog_start_o = prog_q;
  assign prog_addr_o  = prog_addr_q;
  assign prog_data_o  = prog_data_q;
  assign dw_start_o   = dw_q;
  assign dw_addr_o    = dw_addr_q;
  assign dw_data0_o   = dw_d0_q;
  assign dw_data1_o   = dw_d1_q;
  assign cfg_wr_o     = cfgw_q;
  assign bypass_o     = byp_q;
  assign byp_enter_o  = ent_q;
  assign byp_exit_o   = ext_q;

  a_r2_single_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_q, dw_q, cfgw_q, ent_q, ext_q}));
  a_r5_enter_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_q |-> (byp_q && !$past(byp_q)));
  a_r7_exit_clears_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_q |-> (!byp_q && $past(byp_q)));
  a_r12_flag_moves_on_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byp_q != $past(byp_q)) |-> (ent_q || ext_q));
  a_r2_prog_pulse_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_q |=> !prog_q);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16,
  parameter int BLK_W  = 4,
  parameter int CFG_W  = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         data_i,
  input  logic [(1<<BLK_W)-1:0]     prot_mask_i,
  output logic                      prog_start_o,
  output logic [ADDR_W-1:0]         prog_addr_o,
  output logic [DATA_W-1:0]         prog_data_o,
  output logic                      dw_start_o,
  output logic [ADDR_W-1:0]         dw_addr_o,
  output logic [DATA_W-1:0]         dw_data0_o,
  output logic [DATA_W-1:0]         dw_data1_o,
  output logic                      cfg_wr_o,
  output logic [CFG_W-1:0]          cfg_o,
  output logic                      bypass_o,
  output logic                      byp_enter_o,
  output logic                      byp_exit_o
);
  localparam int NUM_BLK = 1 << BLK_W;

  logic             prot_hit;
  logic             cfg_ld;
  logic [CFG_W-1:0] cfg_val;

  fcd_prot_check #(.BLK_W(BLK_W)) u_prot (
    .blk_i  (addr_i[ADDR_W-1 -: BLK_W]),
    .mask_i (prot_mask_i),
    .prot_o (prot_hit)
  );

  fcd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (wr_i),
    .addr_i       (addr_i),
    .data_i       (data_i),
    .prot_i       (prot_hit),
    .prog_start_o (prog_start_o),
    .prog_addr_o  (prog_addr_o),
    .prog_data_o  (prog_data_o),
    .dw_start_o   (dw_start_o),
    .dw_addr_o    (dw_addr_o),
    .dw_data0_o   (dw_data0_o),
    .dw_data1_o   (dw_data1_o),
    .cfg_ld_o     (cfg_ld),
    .cfg_val_o    (cfg_val),
    .cfg_wr_o     (cfg_wr_o),
    .bypass_o     (bypass_o),
    .byp_enter_o  (byp_enter_o),
    .byp_exit_o   (byp_exit_o)
  );

  fcd_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (cfg_ld),
    .val_i  (cfg_val),
    .cfg_o  (cfg_o)
  );

  a_r11_no_start_on_protected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_start_o |->
      !(|($past(prot_mask_i) & (NUM_BLK'(1) << prog_addr_o[ADDR_W-1 -: BLK_W]))));
  a_r8_pair_differs_in_a0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dw_start_o |-> ($past(addr_i) == (dw_addr_o ^ ADDR_W'(1))));
endmodule

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_i = 1'b0;
  logic [20:0] addr_i = '0;
  logic [15:0] data_i = '0;
  logic [15:0] prot_mask = 16'h0008;
  logic        prog_start, dw_start, cfg_wr, bypass, byp_enter, byp_exit;
  logic [20:0] prog_addr, dw_addr;
  logic [15:0] prog_data, dw_d0, dw_d1, cfg;

  int n_vec = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  flash_cmd_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr_i), .addr_i(addr_i), .data_i(data_i),
    .prot_mask_i(prot_mask),
    .prog_start_o(prog_start), .prog_addr_o(prog_addr), .prog_data_o(prog_data),
    .dw_start_o(dw_start), .dw_addr_o(dw_addr), .dw_data0_o(dw_d0), .dw_data1_o(dw_d1),
    .cfg_wr_o(cfg_wr), .cfg_o(cfg), .bypass_o(bypass),
    .byp_enter_o(byp_enter), .byp_exit_o(byp_exit)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_m(input logic [20:0] a, input logic [15:0] d, input logic [15:0] m);
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; data_i = d; prot_mask = m;
    @(posedge clk); #1;
    wr_i = 1'b0;
  endtask

  task automatic wr(input logic [20:0] a, input logic [15:0] d);
    wr_m(a, d, prot_mask);
  endtask

  task automatic unlock();
    wr(21'h555, 16'h00AA);
    wr(21'h2AA, 16'h0055);
  endtask

  task automatic idle_cycle();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R1", "bypass", bypass, 0);
    chk("R1", "cfg", cfg, 0);
    chk("R1", "pulses", {prog_start, dw_start, cfg_wr, byp_enter, byp_exit}, 0);
  endtask

  task automatic t_program();
    unlock(); wr(21'h555, 16'h00A0); wr(21'h01234, 16'hBEEF);
    chk("R2", "prog_start", prog_start, 1);
    chk("R2", "prog_addr", prog_addr, 21'h01234);
    chk("R2", "prog_data", prog_data, 16'hBEEF);
    idle_cycle();
    chk("R2", "pulse width", prog_start, 0);
  endtask

  task automatic t_abort();
    wr(21'h555, 16'h00AA); wr(21'h123, 16'h0055); wr(21'h555, 16'h00A0); wr(21'h00100, 16'h1111);
    chk("R3", "bad unlock addr", prog_start, 0);
    wr(21'h555, 16'h00AA); wr(21'h2AA, 16'h0054); wr(21'h555, 16'h00A0); wr(21'h00100, 16'h2222);
    chk("R3", "bad unlock data", prog_start, 0);
    unlock(); wr(21'h556, 16'h00A0); wr(21'h00100, 16'h3333);
    chk("R3", "bad cmd addr", prog_start, 0);
  endtask

  task automatic t_cfg();
    unlock(); wr(21'h555, 16'h0060); wr(21'h00400, 16'h0003);
    chk("R4", "cfg_wr", cfg_wr, 1);
    chk("R4", "cfg", cfg, 16'h0400);
    unlock(); wr(21'h555, 16'h0060); wr(21'h0FFFF, 16'h0007);
    chk("R4", "cfg_wr bad confirm", cfg_wr, 0);
    chk("R4", "cfg kept", cfg, 16'h0400);
  endtask

  task automatic t_dword();
    unlock(); wr(21'h555, 16'h0040); wr(21'h00100, 16'h1111); wr(21'h00101, 16'h2222);
    chk("R8", "dw_start", dw_start, 1);
    chk("R8", "dw_addr", dw_addr, 21'h00100);
    chk("R8", "dw_data0", dw_d0, 16'h1111);
    chk("R8", "dw_data1", dw_d1, 16'h2222);
  endtask

  task automatic t_pair();
    unlock(); wr(21'h555, 16'h0040); wr(21'h00100, 16'h1111); wr(21'h00102, 16'h2222);
    chk("R10", "other bit differs", dw_start, 0);
    unlock(); wr(21'h555, 16'h0040); wr(21'h00100, 16'h1111); wr(21'h00100, 16'h2222);
    chk("R10", "same address", dw_start, 0);
  endtask

  task automatic t_prot();
    unlock(); wr(21'h555, 16'h00A0); wr(21'h60010, 16'h4444);
    chk("R11", "prog on protected", prog_start, 0);
    unlock(); wr(21'h555, 16'h0040); wr(21'h60010, 16'h4444); wr(21'h60011, 16'h5555);
    chk("R11", "dword on protected", dw_start, 0);
    unlock(); wr(21'h555, 16'h00A0); wr(21'h80010, 16'h6666);
    chk("R11", "prog on open block", prog_start, 1);
  endtask

  task automatic t_enter();
    unlock(); wr(21'h555, 16'h0020);
    chk("R5", "bypass", bypass, 1);
    chk("R5", "byp_enter", byp_enter, 1);
  endtask

  task automatic t_byp_ignore();
    wr(21'h555, 16'h00AA); wr(21'h2AA, 16'h0055); wr(21'h555, 16'h0020);
    chk("R12", "bypass kept", bypass, 1);
    chk("R12", "no pulse", {prog_start, dw_start, cfg_wr, byp_enter, byp_exit}, 0);
  endtask

  task automatic t_byp_prog();
    wr(21'h1ABCD, 16'h00A0); wr(21'h00042, 16'h5A5A);
    chk("R6", "prog_start", prog_start, 1);
    chk("R6", "prog_addr", prog_addr, 21'h00042);
    chk("R6", "prog_data", prog_data, 16'h5A5A);
    // mask clears in the same cycle as the target write; data equals a command code
    wr(21'h00007, 16'h00A0); wr_m(21'h60020, 16'h00A0, 16'h0000);
    chk("R11", "mask same cycle", prog_start, 1);
    chk("R6", "A0 as data", prog_data, 16'h00A0);
    prot_mask = 16'h0008;
    wr(21'h00007, 16'h00A0); wr(21'h60020, 16'h0001);
    chk("R11", "bypass protected", prog_start, 0);
  endtask

  task automatic t_byp_dword();
    wr(21'h00ABC, 16'h0040); wr(21'h00301, 16'h7777); wr(21'h00300, 16'h8888);
    chk("R9", "dw_start", dw_start, 1);
    chk("R9", "dw_addr", dw_addr, 21'h00301);
    chk("R9", "dw_data1", dw_d1, 16'h8888);
  endtask

  task automatic t_exit();
    wr(21'h00000, 16'h0090); wr(21'h00000, 16'h0012);
    chk("R7", "bad confirm keeps bypass", bypass, 1);
    chk("R7", "no exit pulse", byp_exit, 0);
    wr(21'h00000, 16'h0090); wr(21'h00000, 16'h0000);
    chk("R7", "bypass cleared", bypass, 0);
    chk("R7", "byp_exit", byp_exit, 1);
    wr(21'h00000, 16'h00A0); wr(21'h00050, 16'h9999);
    chk("R7", "no short prog after exit", prog_start, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    idle_cycle();
    t_reset();
    t_program();
    t_abort();
    t_cfg();
    t_dword();
    t_pair();
    t_prot();
    t_enter();
    t_byp_ignore();
    t_byp_prog();
    t_byp_dword();
    t_exit();
    idle_cycle();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule